// File: doc/BRIEF.md
# Password Sector Protection Unlock Controller

This block guards a 64-bit protection password and the two mode-lock bits that select how non-volatile sector protection is governed. A host talks to it over a simple synchronous write/read bus. A three-write entry sequence opens one of two command sets: the lock-register set or the password set. A two-write exit sequence closes it again. Inside the password set the host can program the password one 16-bit word at a time, read it back, and run a seven-write unlock sequence. On a full match, that sequence clears the lock that freezes the non-volatile protection bits.

Both the password and the lock register are held in ordinary flops. Their reset values stand in for an erased part. Persistent mode and password mode are mutually exclusive. Any program that would leave both modes locked is thrown away, so the register remains in the default persistent mode. Once password mode is locked, the stored words can no longer be read or rewritten. They only serve the unlock comparison.

Top module: `ppw_ctrl`

## Requirements
- R1: When no set is open, the writes 0xAA at address 0x555, then 0x55 at 0x2AA, then 0x40 at 0x555 open the lock-register set. The same first two writes followed by 0x60 at 0x555 open the password set. Any other write in the sequence abandons it, and only a fresh 0xAA at 0x555 starts it again. Only data bits 7:0 count as the command byte. `cmd_set` reads 0 for no set, 1 for the lock-register set and 2 for the password set, and it changes on the clock edge of the last write.
- R2: Inside an open set, a write of 0x90 followed directly by a write of 0x00 closes the set. Reads made while no set is open return 0, and `rdata` resets to 0.
- R3: In the password set, a write of 0xA0 followed by a write at address w (w in 0..3, all higher address bits zero) stores the data as password word w. A read at address w returns that word in `rdata` one cycle after `rd_en`. The words reset to 0xFFFF.
- R4: In the lock-register set, a read at address 0 returns the lock register. Bit 0 is 1, bit 1 is the persistent-mode lock, bit 2 is the password-mode lock (0 means locked), and bits 15:3 are 1. The register resets to 0xFFFF.
- R5: In the lock-register set, a write of 0xA0 followed by a write at address 0 replaces each mode-lock bit with its old value ANDed with the matching data bit, so a locked bit never returns to 1. If the second write is at a non-zero address, it changes nothing. `pers_mode_locked` and `pwd_mode_locked` are the inverted bits.
- R6: A lock-register program whose result would lock both modes is discarded, and both bits keep their previous values.
- R7: Once password mode is locked, password reads return 0xFFFF and password programming has no effect.
- R8: `ppb_locked` resets to 1. It drops to 0 when an unlock sequence completes, every supplied word equals the stored word, and password mode is locked. `unlock_fail` is cleared at the same time.
- R9: The unlock sequence is seven writes: 0x25 at 0, 0x03 at 0, password words 0 to 3 at addresses 0 to 3, then 0x29 at 0. On its last write, a mismatch in any word, or password mode not being locked, sets `unlock_fail` and leaves `ppb_locked` unchanged.
- R10: If a write inside the unlock sequence has the wrong address or code, the sequence is dropped with no change to `ppb_locked` or `unlock_fail`. That write is then decoded as a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one bus cycle |
| rd_en | input | 1 | Read strobe for one bus cycle |
| addr | input | 11 | Word address of the bus cycle |
| wdata | input | 16 | Write data; bits 7:0 carry command codes |
| rdata | output | 16 | Read data, registered, valid the cycle after `rd_en` |
| cmd_set | output | 2 | Open command set: 0 none, 1 lock register, 2 password |
| pers_mode_locked | output | 1 | Persistent protection mode is locked |
| pwd_mode_locked | output | 1 | Password protection mode is locked |
| ppb_locked | output | 1 | Non-volatile protection bits are frozen |
| unlock_fail | output | 1 | Last completed unlock sequence did not match |

## Verification
Two situations are hard to reach. The first is a correct unlock that follows a failed one while password mode is locked: the stored words can no longer be read, so the expected match has to come from the values the bench itself programmed before the lock was set. The stimulus therefore programs the words first, locks password mode through the lock-register set, tries to overwrite a word, and only then runs a mismatching sequence, a broken one and a correct one. The second is an unlock sequence broken by an exit code. It is driven as four word writes followed by 0x90 and 0x00, which must close the set without touching either flag.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_LOCK = 2'd1,
        CS_PWD  = 2'd2
    } cset_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PROG,
        OP_EXIT,
        OP_UCNT,
        OP_UWORD,
        OP_UGO
    } op_e;

    localparam logic [10:0] A_FIRST   = 11'h555;
    localparam logic [10:0] A_SECOND  = 11'h2AA;

    localparam logic [7:0] C_KEY1     = 8'hAA;
    localparam logic [7:0] C_KEY2     = 8'h55;
    localparam logic [7:0] C_ENT_LOCK = 8'h40;
    localparam logic [7:0] C_ENT_PWD  = 8'h60;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_EXIT1    = 8'h90;
    localparam logic [7:0] C_EXIT2    = 8'h00;
    localparam logic [7:0] C_UL_START = 8'h25;
    localparam logic [7:0] C_UL_GO    = 8'h29;

endpackage

// File: rtl/ppw_entry.sv
module ppw_entry
    import ppw_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd,
    input  logic              leave,
    output cset_e             cset
);

    typedef struct packed {
        cset_e      cset;
        logic [1:0] step;
    } ent_t;

    ent_t q, d;

    logic at_first, at_second;
    assign at_first  = (addr == ADDR_W'(A_FIRST));
    assign at_second = (addr == ADDR_W'(A_SECOND));

    always_comb begin
        d = q;
        if (leave) begin
            d.cset = CS_NONE;
            d.step = 2'd0;
        end else if (wr_en && q.cset == CS_NONE) begin
            case (q.step)
                2'd0: d.step = (at_first && cmd == C_KEY1) ? 2'd1 : 2'd0;
                2'd1: begin
                    if (at_second && cmd == C_KEY2)
                        d.step = 2'd2;
                    else if (at_first && cmd == C_KEY1)
                        d.step = 2'd1;
                    else
                        d.step = 2'd0;
                end
                default: begin
                    d.step = 2'd0;
                    if (at_first && cmd == C_ENT_LOCK)
                        d.cset = CS_LOCK;
                    else if (at_first && cmd == C_ENT_PWD)
                        d.cset = CS_PWD;
                    else if (at_first && cmd == C_KEY1)
                        d.step = 2'd1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cset <= CS_NONE;
            q.step <= 2'd0;
        end else begin
            q <= d;
        end
    end

    assign cset = q.cset;

    assert_leave_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (cset == CS_NONE));

    assert_set_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cset != CS_NONE && !leave) |=> $stable(cset));

endmodule

// File: rtl/ppw_lockreg.sv
module ppw_lockreg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic [1:0] prog_bits,
    output logic       pers_n,
    output logic       pwd_n
);

    typedef struct packed {
        logic pers_n;
        logic pwd_n;
    } lr_t;

    lr_t q, d;
    lr_t cand;

    always_comb begin
        d = q;
        cand.pers_n = q.pers_n & prog_bits[0];
        cand.pwd_n  = q.pwd_n  & prog_bits[1];
        if (prog_en && (cand.pers_n || cand.pwd_n))
            d = cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pers_n <= 1'b1;
            q.pwd_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pers_n = q.pers_n;
    assign pwd_n  = q.pwd_n;

    assert_modes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pers_n || q.pwd_n));

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pwd_n || !q.pers_n) |=> ($past(q.pwd_n) || !q.pwd_n) && ($past(q.pers_n) || !q.pers_n));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(q));

endmodule

// File: rtl/ppw_pwd_store.sv
module ppw_pwd_store #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);

    logic [WORDS-1:0][DATA_W-1:0] words_q, words_d;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_comb begin
            words_d[g] = words_q[g];
            if (we && idx == IDX_W'(g))
                words_d[g] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            words_q <= '1;
        else
            words_q <= words_d;
    end

    assign word = words_q[idx];

    assert_words_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words_q));

endmodule

// File: rtl/ppw_ctrl.sv
module ppw_ctrl
    import ppw_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 16,
    parameter int PWD_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        cmd_set,
    output logic              pers_mode_locked,
    output logic              pwd_mode_locked,
    output logic              ppb_locked,
    output logic              unlock_fail
);

    localparam int IDX_W = (PWD_WORDS > 1) ? $clog2(PWD_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PWD_WORDS - 1);
    localparam logic [7:0] C_UL_CNT = 8'(PWD_WORDS - 1);

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] widx;
        logic             match;
        logic             ppb;
        logic             fail;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t q, d;

    cset_e             cset;
    logic              leave;
    logic              lr_prog;
    logic              pers_n, pwd_n;
    logic              pw_we;
    logic [DATA_W-1:0] pw_word;
    logic [7:0]        cmd;
    logic              at_zero, word_ofs_ok, in_set;
    op_e               fresh;

    assign cmd         = wdata[7:0];
    assign at_zero     = (addr == '0);
    assign word_ofs_ok = (addr[ADDR_W-1:IDX_W] == '0);
    assign in_set      = (cset != CS_NONE);

    ppw_entry #(.ADDR_W(ADDR_W)) u_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .cmd   (cmd),
        .leave (leave),
        .cset  (cset)
    );

    ppw_lockreg u_lockreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (lr_prog),
        .prog_bits (wdata[2:1]),
        .pers_n    (pers_n),
        .pwd_n     (pwd_n)
    );

    ppw_pwd_store #(.DATA_W(DATA_W), .WORDS(PWD_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pw_we),
        .idx   (addr[IDX_W-1:0]),
        .wdata (wdata),
        .word  (pw_word)
    );

    always_comb begin
        fresh = OP_IDLE;
        if (cmd == C_PROG)
            fresh = OP_PROG;
        else if (cmd == C_EXIT1)
            fresh = OP_EXIT;
        else if (cset == CS_PWD && cmd == C_UL_START && at_zero)
            fresh = OP_UCNT;
    end

    always_comb begin
        d       = q;
        leave   = 1'b0;
        lr_prog = 1'b0;
        pw_we   = 1'b0;

        if (!in_set) begin
            d.op = OP_IDLE;
        end else if (wr_en) begin
            case (q.op)
                OP_PROG: begin
                    d.op = OP_IDLE;
                    if (cset == CS_LOCK && at_zero)
                        lr_prog = 1'b1;
                    if (cset == CS_PWD && word_ofs_ok && pwd_n)
                        pw_we = 1'b1;
                end
                OP_EXIT: begin
                    if (cmd == C_EXIT2) begin
                        leave = 1'b1;
                        d.op  = OP_IDLE;
                    end else begin
                        d.op = fresh;
                    end
                end
                OP_UCNT: begin
                    if (cmd == C_UL_CNT && at_zero) begin
                        d.op    = OP_UWORD;
                        d.widx  = '0;
                        d.match = 1'b1;
                    end else begin
                        d.op = fresh;
                    end
                end
                OP_UWORD: begin
                    if (word_ofs_ok && addr[IDX_W-1:0] == q.widx) begin
                        d.match = q.match && (wdata == pw_word);
                        if (q.widx == LAST_IDX)
                            d.op = OP_UGO;
                        else
                            d.widx = q.widx + 1'b1;
                    end else begin
                        d.op = fresh;
                    end
                end
                OP_UGO: begin
                    if (cmd == C_UL_GO && at_zero) begin
                        d.op = OP_IDLE;
                        if (q.match && !pwd_n) begin
                            d.ppb  = 1'b0;
                            d.fail = 1'b0;
                        end else begin
                            d.fail = 1'b1;
                        end
                    end else begin
                        d.op = fresh;
                    end
                end
                default: d.op = fresh;
            endcase
        end

        if (rd_en) begin
            case (cset)
                CS_LOCK: d.rdata = at_zero ? {{(DATA_W-3){1'b1}}, pwd_n, pers_n, 1'b1} : '0;
                CS_PWD:  d.rdata = word_ofs_ok ? (pwd_n ? pw_word : '1) : '0;
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.op    <= OP_IDLE;
            q.widx  <= '0;
            q.match <= 1'b0;
            q.ppb   <= 1'b1;
            q.fail  <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata            = q.rdata;
    assign cmd_set          = cset;
    assign pers_mode_locked = ~pers_n;
    assign pwd_mode_locked  = ~pwd_n;
    assign ppb_locked       = q.ppb;
    assign unlock_fail      = q.fail;

    assert_unlock_needs_pwd_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ppb_locked) |-> pwd_mode_locked);

    assert_fail_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_fail) |-> ($past(wr_en) && cmd_set == 2'd2));

    assert_locked_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cset == CS_PWD && word_ofs_ok && pwd_mode_locked) |=> (rdata == '1));

    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cset == CS_NONE) |=> (rdata == '0));

endmodule

// File: tb/ppw_ctrl_test.sv
module ppw_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 62;

    // vector: {req[3:0], kind[1:0], addr[11:0], data[15:0]}
    // kind 0 = write, 1 = read and compare rdata, 2 = compare status
    // status = {cmd_set[1:0], pers_mode_locked, pwd_mode_locked, ppb_locked, unlock_fail}
    localparam logic [33:0] VEC [NV] = '{
        {4'd8, 2'd2, 12'h000, 16'h0002},   // R8 reset status
        {4'd1, 2'd0, 12'h555, 16'h00AA},   // R1 open password set
        {4'd1, 2'd0, 12'h2AA, 16'h0055},
        {4'd1, 2'd0, 12'h555, 16'h0060},
        {4'd1, 2'd2, 12'h000, 16'h0022},
        {4'd3, 2'd0, 12'h000, 16'h00A0},   // R3 program four words
        {4'd3, 2'd0, 12'h000, 16'h1234},
        {4'd3, 2'd0, 12'h000, 16'h00A0},
        {4'd3, 2'd0, 12'h001, 16'hABCD},
        {4'd3, 2'd0, 12'h000, 16'h00A0},
        {4'd3, 2'd0, 12'h002, 16'h0F0F},
        {4'd3, 2'd0, 12'h000, 16'h00A0},
        {4'd3, 2'd0, 12'h003, 16'h55AA},
        {4'd3, 2'd1, 12'h000, 16'h1234},
        {4'd3, 2'd1, 12'h003, 16'h55AA},
        {4'd2, 2'd0, 12'h000, 16'h0090},   // R2 close set
        {4'd2, 2'd0, 12'h000, 16'h0000},
        {4'd2, 2'd2, 12'h000, 16'h0002},
        {4'd2, 2'd1, 12'h000, 16'h0000},
        {4'd1, 2'd0, 12'h555, 16'h00AA},   // R1 open lock-register set
        {4'd1, 2'd0, 12'h2AA, 16'h0055},
        {4'd1, 2'd0, 12'h555, 16'h0040},
        {4'd1, 2'd2, 12'h000, 16'h0012},
        {4'd4, 2'd1, 12'h000, 16'hFFFF},   // R4 reset value
        {4'd6, 2'd0, 12'h000, 16'h00A0},   // R6 both locks at once
        {4'd6, 2'd0, 12'h000, 16'hFFF9},
        {4'd6, 2'd1, 12'h000, 16'hFFFF},
        {4'd5, 2'd0, 12'h000, 16'h00A0},   // R5 non-zero address ignored
        {4'd5, 2'd0, 12'h004, 16'hFFFB},
        {4'd5, 2'd1, 12'h000, 16'hFFFF},
        {4'd5, 2'd0, 12'h000, 16'h00A0},   // R5 lock password mode
        {4'd5, 2'd0, 12'h000, 16'hFFFB},
        {4'd5, 2'd1, 12'h000, 16'hFFFB},
        {4'd2, 2'd0, 12'h000, 16'h0090},   // R2 close, R1 reopen password set
        {4'd2, 2'd0, 12'h000, 16'h0000},
        {4'd1, 2'd0, 12'h555, 16'h00AA},
        {4'd1, 2'd0, 12'h2AA, 16'h0055},
        {4'd1, 2'd0, 12'h555, 16'h0060},
        {4'd1, 2'd2, 12'h000, 16'h0026},
        {4'd7, 2'd1, 12'h001, 16'hFFFF},   // R7 locked read
        {4'd7, 2'd0, 12'h000, 16'h00A0},   // R7 program must be ignored
        {4'd7, 2'd0, 12'h001, 16'h0000},
        {4'd9, 2'd0, 12'h000, 16'h0025},   // R9 mismatch in word 2
        {4'd9, 2'd0, 12'h000, 16'h0003},
        {4'd9, 2'd0, 12'h000, 16'h1234},
        {4'd9, 2'd0, 12'h001, 16'hABCD},
        {4'd9, 2'd0, 12'h002, 16'h0F0E},
        {4'd9, 2'd0, 12'h003, 16'h55AA},
        {4'd9, 2'd0, 12'h000, 16'h0029},
        {4'd9, 2'd2, 12'h000, 16'h0027},
        {4'd10, 2'd0, 12'h000, 16'h0025},  // R10 wrong address for word 0
        {4'd10, 2'd0, 12'h000, 16'h0003},
        {4'd10, 2'd0, 12'h001, 16'h1234},
        {4'd10, 2'd2, 12'h000, 16'h0027},
        {4'd8, 2'd0, 12'h000, 16'h0025},   // R8 correct unlock
        {4'd8, 2'd0, 12'h000, 16'h0003},
        {4'd8, 2'd0, 12'h000, 16'h1234},
        {4'd8, 2'd0, 12'h001, 16'hABCD},
        {4'd8, 2'd0, 12'h002, 16'h0F0F},
        {4'd8, 2'd0, 12'h003, 16'h55AA},
        {4'd8, 2'd0, 12'h000, 16'h0029},
        {4'd8, 2'd2, 12'h000, 16'h0024}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  cmd_set;
    logic        pers_mode_locked, pwd_mode_locked, ppb_locked, unlock_fail;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ppw_ctrl uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .rd_en            (rd_en),
        .addr             (addr),
        .wdata            (wdata),
        .rdata            (rdata),
        .cmd_set          (cmd_set),
        .pers_mode_locked (pers_mode_locked),
        .pwd_mode_locked  (pwd_mode_locked),
        .ppb_locked       (ppb_locked),
        .unlock_fail      (unlock_fail)
    );

    function automatic logic [15:0] status();
        return {10'd0, cmd_set, pers_mode_locked, pwd_mode_locked, ppb_locked, unlock_fail};
    endfunction

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [10:0] a, input logic [15:0] v);
        wr_en = 1'b1;
        addr  = a;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int req, input logic [10:0] a, input logic [15:0] exp);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic open_set(input logic [7:0] code);
        do_wr(11'h555, 16'h00AA);
        do_wr(11'h2AA, 16'h0055);
        do_wr(11'h555, {8'h00, code});
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][29:28])
                2'd0: do_wr(VEC[i][26:16], VEC[i][15:0]);
                2'd1: do_rd(int'(VEC[i][33:30]), VEC[i][26:16], VEC[i][15:0]);
                default: check(int'(VEC[i][33:30]), status(), VEC[i][15:0]);
            endcase
        end

        // R2: reset brings rdata back to zero; R8: status back to reset value
        do_reset();
        check(2, rdata, 16'h0000);
        check(8, status(), 16'h0002);

        // R1: a wrong third code abandons the entry
        open_set(8'h41);
        check(1, status(), 16'h0002);

        // R1: bits above the command byte are ignored
        do_wr(11'h555, 16'h12AA);
        do_wr(11'h2AA, 16'h3455);
        do_wr(11'h555, 16'hFF60);
        check(1, status(), 16'h0022);

        // R9: matching words while password mode is not locked still fail
        do_wr(11'h000, 16'h0025);
        do_wr(11'h000, 16'h0003);
        for (int w = 0; w < 4; w++) do_wr(11'(w), 16'hFFFF);
        do_wr(11'h000, 16'h0029);
        check(9, status(), 16'h0023);

        // R10: exit code inside the sequence drops it and closes the set
        do_reset();
        open_set(8'h60);
        do_wr(11'h000, 16'h0025);
        do_wr(11'h000, 16'h0003);
        for (int w = 0; w < 4; w++) do_wr(11'(w), 16'h0000);
        do_wr(11'h000, 16'h0090);
        do_wr(11'h000, 16'h0000);
        check(10, status(), 16'h0002);

        // R5: lock persistent mode, then R6: password lock on top is refused
        do_reset();
        open_set(8'h40);
        do_wr(11'h000, 16'h00A0);
        do_wr(11'h000, 16'hFFFD);
        do_rd(5, 11'h000, 16'hFFFD);
        check(5, status(), 16'h0016 ^ 16'h000C);
        do_wr(11'h000, 16'h00A0);
        do_wr(11'h000, 16'hFFFB);
        do_rd(6, 11'h000, 16'hFFFD);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule